// File: doc/BRIEF.md
# USB High-Priority Interrupt Controller

This block gathers the urgent events of a full-speed USB device into sticky flags and raises a single interrupt request toward the microcontroller core. The serial interface engine sends one-cycle pulses for two kinds of event. The first is the completion of a setup stage on endpoint 0 or endpoint 1. The second is a STALL handshake sent on endpoint 0, 1 or 2. A level input reports activity on the bus. A rising edge on that level records a resume event, so that any traffic can wake a suspended device.

Some endpoints exist only in certain configurations. A 3-bit endpoint-mode input therefore decides whether the endpoint-1 and endpoint-2 events may set their flags. The firmware reads the flags through a small register port and acknowledges them by writing ones. A mask register selects which flags may drive the interrupt line.

Top module: `usbhp_irq_ctrl`

## Requirements
- R1: After reset the flags and the mask are all zero, `irq` is low and `reg_rdata` is zero.
- R2: The flag bits are ordered from bit 0 as follows: setup EP0, setup EP1, resume, stall EP0, stall EP1, stall EP2. A pulse on `ev_setup_ep0` sets bit 0 and a pulse on `ev_stall_ep0` sets bit 3, in every endpoint mode. The flag is set at the clock edge that samples the pulse.
- R3: A pulse on `ev_setup_ep1` sets bit 1 only while `ep_mode` is 3'b011. In every other mode the pulse leaves the bit at 0.
- R4: A pulse on `ev_stall_ep1` sets bit 4 in every mode except 3'b000.
- R5: A pulse on `ev_stall_ep2` sets bit 5 only in the modes 3'b100 to 3'b111, that is, when `ep_mode[2]` is 1.
- R6: A 0-to-1 change of `bus_activity` sets bit 2 at the edge that first samples the 1. A level that stays high does not set the bit again after it has been cleared.
- R7: A write to address 0 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. If a set event and a clear hit the same flag in the same cycle, the flag stays set.
- R8: Address 1 holds the mask in data bits [5:0]. A mask bit of 1 lets the matching flag drive `irq`.
- R9: `irq` is registered. One cycle after any flag and its mask bit are both 1, `irq` is 1. It stays 1 for as long as such a pair remains, and it is 0 one cycle after none remains.
- R10: A read strobe loads `reg_rdata` at the clock edge with the register value from before that edge. Address 0 returns the flags and address 1 returns the mask. Bits above 5, and every other address, read 0. `reg_rdata` holds its value between reads.
- R11: A write to the mask address does not change the flags. A write to an unused address changes neither the flags nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address (0 flags, 1 mask) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| ev_setup_ep0 | input | 1 | Setup stage done on endpoint 0 (pulse) |
| ev_setup_ep1 | input | 1 | Setup stage done on endpoint 1 (pulse) |
| ev_stall_ep0 | input | 1 | STALL sent on endpoint 0 (pulse) |
| ev_stall_ep1 | input | 1 | STALL sent on endpoint 1 (pulse) |
| ev_stall_ep2 | input | 1 | STALL sent on endpoint 2 (pulse) |
| bus_activity | input | 1 | Bus activity status level |
| ep_mode | input | 3 | Endpoint configuration mode |
| irq | output | 1 | Interrupt request to the core |

## Verification
The hardest case to reach is an event pulse and a write-1 acknowledge that land on the same flag in the same cycle. The bench drives the event and the register write in one cycle on purpose. It also puts them in random traffic, so that the set-wins rule meets the acknowledge path. The mode gating is walked through all eight modes with every event pulsed at once. This exposes any wrong decode of a mode boundary. The resume edge is tested with a level that stays high after its flag has been cleared.

// File: rtl/usbhp_pkg.sv
package usbhp_pkg;
   localparam int NUM_SRC    = 6;
   localparam int MODE_W     = 3;
   localparam int BIT_SETUP0 = 0;
   localparam int BIT_SETUP1 = 1;
   localparam int BIT_RESUME = 2;
   localparam int BIT_STALL0 = 3;
   localparam int BIT_STALL1 = 4;
   localparam int BIT_STALL2 = 5;

   typedef logic [NUM_SRC-1:0] src_vec_t;
   typedef logic [MODE_W-1:0]  mode_t;

   localparam mode_t MODE_ALL_OFF  = 3'b000;
   localparam mode_t MODE_EP1_CTRL = 3'b011;
endpackage

// File: rtl/usbhp_edge_rise.sv
module usbhp_edge_rise (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level_i;
   end

   assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/usbhp_mode_gate.sv
module usbhp_mode_gate
   import usbhp_pkg::*;
(
   input  mode_t    ep_mode_i,
   input  src_vec_t raw_i,
   output src_vec_t gated_o
);
   src_vec_t allow;

   always_comb begin
      allow             = '1;
      allow[BIT_SETUP1] = (ep_mode_i == MODE_EP1_CTRL);
      allow[BIT_STALL1] = (ep_mode_i != MODE_ALL_OFF);
      allow[BIT_STALL2] = ep_mode_i[MODE_W-1];
   end

   assign gated_o = raw_i & allow;
endmodule

// File: rtl/usbhp_flag_bank.sv
module usbhp_flag_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_o[i] <= 1'b0;
         else if (set_i[i]) flag_o[i] <= 1'b1;
         else if (clr_i[i]) flag_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/usbhp_irq_ctrl.sv
module usbhp_irq_ctrl
   import usbhp_pkg::*;
#(
   parameter int          DATA_W         = 8,
   parameter int          ADDR_W         = 2,
   parameter int          FLAG_ADDR      = 0,
   parameter int          MASK_ADDR      = 1,
   parameter logic [5:0]  MASK_RESET     = 6'h00,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ev_setup_ep0,
   input  logic              ev_setup_ep1,
   input  logic              ev_stall_ep0,
   input  logic              ev_stall_ep1,
   input  logic              ev_stall_ep2,
   input  logic              bus_activity,
   input  logic [2:0]        ep_mode,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
   localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);

   initial begin : elab_checks
      if (DATA_W < NUM_SRC) $fatal(1, "DATA_W must hold all flag bits");
      if (FLAG_ADDR == MASK_ADDR) $fatal(1, "flag and mask addresses collide");
      if (FLAG_ADDR >= (1 << ADDR_W) || MASK_ADDR >= (1 << ADDR_W))
         $fatal(1, "register address out of range");
   end

   logic     act_rise;
   src_vec_t raw_set, set_vec, clr_vec, flag_q, mask_q;
   logic     wr_flag, wr_mask, pend;

   usbhp_edge_rise u_act (
      .clk(clk), .rst_n(rst_n), .level_i(bus_activity), .rise_o(act_rise)
   );

   always_comb begin
      raw_set             = '0;
      raw_set[BIT_SETUP0] = ev_setup_ep0;
      raw_set[BIT_SETUP1] = ev_setup_ep1;
      raw_set[BIT_RESUME] = act_rise;
      raw_set[BIT_STALL0] = ev_stall_ep0;
      raw_set[BIT_STALL1] = ev_stall_ep1;
      raw_set[BIT_STALL2] = ev_stall_ep2;
   end

   usbhp_mode_gate u_gate (
      .ep_mode_i(ep_mode), .raw_i(raw_set), .gated_o(set_vec)
   );

   assign wr_flag = reg_wr && (reg_addr == FLAG_A);
   assign wr_mask = reg_wr && (reg_addr == MASK_A);
   assign clr_vec = wr_flag ? reg_wdata[NUM_SRC-1:0] : '0;

   usbhp_flag_bank #(.N(NUM_SRC)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .flag_o(flag_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= MASK_RESET;
      else if (wr_mask) mask_q <= reg_wdata[NUM_SRC-1:0];
   end

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (reg_addr == FLAG_A)      rd_mux[NUM_SRC-1:0] = flag_q;
      else if (reg_addr == MASK_A) rd_mux[NUM_SRC-1:0] = mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

   assign pend = |(flag_q & mask_q);

   if (IRQ_REGISTERED) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= pend;
      end
   end else begin : g_irq_comb
      assign irq = pend;
   end
endmodule

// File: rtl/usbhp_irq_chk.sv
module usbhp_irq_chk #(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 2,
   parameter int FLAG_ADDR      = 0,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              ev_setup_ep0,
   input logic              ev_setup_ep1,
   input logic              ev_stall_ep1,
   input logic              ev_stall_ep2,
   input logic [2:0]        ep_mode,
   input logic [5:0]        flag_q,
   input logic [5:0]        mask_q,
   input logic              irq
);
   logic [5:0] clr_c;
   assign clr_c = (reg_wr && reg_addr == ADDR_W'(FLAG_ADDR)) ? reg_wdata[5:0] : 6'h00;

   assert_setup0_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_setup_ep0 |=> flag_q[0]);

   assert_setup1_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_setup_ep1 && ep_mode != 3'b011 && !flag_q[1]) |=> !flag_q[1]);

   assert_stall1_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stall_ep1 && ep_mode == 3'b000 && !flag_q[4]) |=> !flag_q[4]);

   assert_stall2_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stall_ep2 && !ep_mode[2] && !flag_q[5]) |=> !flag_q[5]);

   assert_clear_setup0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_c[0] && !ev_setup_ep0) |=> !flag_q[0]);

   for (genvar i = 0; i < 6; i++) begin : g_sticky
      assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !clr_c[i]) |=> flag_q[i]);
   end

   if (IRQ_REGISTERED) begin : g_irq
      assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (|(flag_q & mask_q)) |=> irq);
      assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(flag_q & mask_q)) |=> !irq);
   end
endmodule

bind usbhp_irq_ctrl usbhp_irq_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .IRQ_REGISTERED(IRQ_REGISTERED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .ev_setup_ep0(ev_setup_ep0), .ev_setup_ep1(ev_setup_ep1), .ev_stall_ep1(ev_stall_ep1),
   .ev_stall_ep2(ev_stall_ep2), .ep_mode(ep_mode), .flag_q(flag_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/sim_usbhp_irq_ctrl.sv
`timescale 1ns/1ps
module sim_usbhp_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 0, reg_rd = 0;
   logic [1:0] reg_addr = 0;
   logic [7:0] reg_wdata = 0;
   logic [7:0] reg_rdata;
   logic       ev_s0 = 0, ev_s1 = 0, ev_t0 = 0, ev_t1 = 0, ev_t2 = 0;
   logic       act = 0;
   logic [2:0] mode = 0;
   logic       irq;

   int checks = 0, failures = 0, cycles = 0;
   bit live = 0;

   always #5 clk = ~clk;

   usbhp_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_setup_ep0(ev_s0),
      .ev_setup_ep1(ev_s1), .ev_stall_ep0(ev_t0), .ev_stall_ep1(ev_t1),
      .ev_stall_ep2(ev_t2), .bus_activity(act), .ep_mode(mode), .irq(irq)
   );

   // behavioural reference model
   logic [5:0] m_flags = 0, m_mask = 0;
   logic [7:0] m_rdata = 0;
   logic       m_irq = 0, m_prev_act = 0;

   always @(posedge clk) begin
      logic [5:0] s, c;
      logic [7:0] sel;
      if (!rst_n) begin
         m_flags = 0; m_mask = 0; m_rdata = 0; m_irq = 0; m_prev_act = 0;
      end else begin
         s = 0;
         s[0] = ev_s0;
         s[1] = ev_s1 && mode == 3;
         s[2] = act && !m_prev_act;
         s[3] = ev_t0;
         s[4] = ev_t1 && mode != 0;
         s[5] = ev_t2 && mode >= 4;
         c = (reg_wr && reg_addr == 0) ? reg_wdata[5:0] : 6'h0;
         sel = (reg_addr == 0) ? {2'b00, m_flags} : (reg_addr == 1) ? {2'b00, m_mask} : 8'h00;
         if (reg_rd) m_rdata = sel;
         m_irq = (m_flags & m_mask) != 0;
         m_flags = (m_flags & ~c) | s;
         if (reg_wr && reg_addr == 1) m_mask = reg_wdata[5:0];
         m_prev_act = act;
      end
   end

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (live) begin
         check("R9 irq vs model", {7'b0, irq}, {7'b0, m_irq});
         check("R10 rdata vs model", reg_rdata, m_rdata);
      end
      if (cycles > 150000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic tick(); @(negedge clk); endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_rd = 1; reg_addr = a; tick(); reg_rd = 0; d = reg_rdata;
   endtask

   initial begin
      logic [7:0] v;
      logic [7:0] exp;
      tick(); tick();
      check("R1 irq at reset", {7'b0, irq}, 8'h00);
      check("R1 rdata at reset", reg_rdata, 8'h00);
      rst_n = 1; live = 1;
      rd(0, v); check("R1 flags after reset", v, 8'h00);
      rd(1, v); check("R1 mask after reset", v, 8'h00);

      // R2 R3 R4 R5: all events in every mode
      for (int m = 0; m < 8; m++) begin
         mode = 3'(m);
         wr(0, 8'hFF);
         ev_s0 = 1; ev_s1 = 1; ev_t0 = 1; ev_t1 = 1; ev_t2 = 1; tick();
         ev_s0 = 0; ev_s1 = 0; ev_t0 = 0; ev_t1 = 0; ev_t2 = 0;
         rd(0, v);
         exp = 8'h09 | ((m == 3) ? 8'h02 : 8'h00) | ((m != 0) ? 8'h10 : 8'h00) | ((m >= 4) ? 8'h20 : 8'h00);
         check("R2,R3,R4,R5 mode gating", v, exp);
      end
      wr(0, 8'hFF);

      // R6 resume edge
      act = 1; tick();
      rd(0, v); check("R6 resume on rising activity", v, 8'h04);
      wr(0, 8'h04); tick(); tick();
      rd(0, v); check("R6 steady activity no re-set", v, 8'h00);
      act = 0; tick();

      // R7 set wins and write-0 no effect
      reg_wr = 1; reg_addr = 0; reg_wdata = 8'h01; ev_s0 = 1; tick();
      reg_wr = 0; ev_s0 = 0;
      rd(0, v); check("R7 set beats clear", v, 8'h01);
      wr(0, 8'h00);
      rd(0, v); check("R7 write 0 keeps flag", v, 8'h01);

      // R8 R9 mask and irq
      check("R9 irq low while masked", {7'b0, irq}, 8'h00);
      wr(1, 8'hFF);
      rd(1, v); check("R8 mask readback upper bits zero", v, 8'h3F);
      tick();
      check("R8,R9 irq with unmasked flag", {7'b0, irq}, 8'h01);
      wr(1, 8'h3E); tick();
      check("R8 irq drops when masked", {7'b0, irq}, 8'h00);
      rd(0, v); check("R11 mask write keeps flags", v, 8'h01);

      // R10 R11 unused address
      wr(3, 8'hFF);
      rd(3, v); check("R10 unused address reads 0", v, 8'h00);
      rd(1, v); check("R11 unused write keeps mask", v, 8'h3E);
      rd(0, v); check("R11 unused write keeps flags", v, 8'h01);
      wr(0, 8'h01); tick();
      check("R7,R9 irq low after clear", {7'b0, irq}, 8'h00);

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         r = $urandom;
         ev_s0 = r[0] & r[1]; ev_s1 = r[2] & r[3]; ev_t0 = r[4] & r[5];
         ev_t1 = r[6] & r[7]; ev_t2 = r[8] & r[9];
         act = (r[12:10] == 0) ? ~act : act;
         if (r[15:13] == 0) mode = r[18:16];
         reg_wr = r[19] & r[20]; reg_rd = r[21]; reg_addr = r[23:22];
         reg_wdata = r[31:24];
         tick();
      end
      ev_s0 = 0; ev_s1 = 0; ev_t0 = 0; ev_t1 = 0; ev_t2 = 0; reg_wr = 0; reg_rd = 0;
      tick(); tick();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule